// File: doc/BRIEF.md
# Format-Configurable Asynchronous Serial Transmitter

This block turns a byte handed over by a host into one asynchronous serial frame on a single output line. The host presents a byte together with a one-cycle load strobe. The byte goes into a holding buffer, and the host watches a buffer-empty flag to know when it may hand over the next byte. When the transmitter is free it moves the buffered byte into its shift register and sends a start bit, the data bits, an optional parity bit and one or two stop bits. Bit timing comes from an enable tick supplied by an external baud generator.

A 3-bit format code picks one of eight frame layouts: 7 or 8 data bits, even, odd or no parity, and one or two stop bits. The code is sampled when a frame begins, so the host may change it for the next frame while the current one is still going out. The reset input is the combined reset: the system reset ORed with any software reset command decoded elsewhere. It abandons any frame in progress and discards a queued byte.

The controller is a five-state machine. IDLE holds the line high and waits for a full buffer. The take transition (IDLE to START, or STOP to START when another byte is waiting) moves the buffer into the shift register. START drives the low start bit. The start-done transition goes to DATA, which shifts the data out LSB first. The data-done transition goes to PARITY when the format has a parity bit and to STOP when it does not, and the parity-done transition goes to STOP. STOP drives the high stop bits, and the frame-done transition goes to START when the buffer is full and to IDLE when it is empty.

Top module: `uart_tx_framer`

## Requirements
- R1: Format codes 3'b000, 3'b001, 3'b010 and 3'b011 send 7 data bits followed by a parity bit: even parity with 2 stop bits, odd parity with 2 stop bits, even parity with 1 stop bit, and odd parity with 1 stop bit, in that code order.
- R2: Format codes 3'b100 and 3'b101 send 8 data bits with no parity, followed by 2 and 1 stop bits respectively. Codes 3'b110 and 3'b111 send 8 data bits, then an even or an odd parity bit respectively, then 1 stop bit.
- R3: The line idles high. A frame is a low start bit, then the data bits LSB first, then the parity bit if the format has one, then high stop bits. Even parity makes the count of ones over the data and parity bits even, and odd parity makes it odd.
- R4: A load strobe captures din into the holding buffer at that clock edge, and buf_empty is low after that edge.
- R5: The cycle after the buffer fills while the line is idle, the start bit appears and buf_empty returns high. A byte loaded during a frame waits in the buffer, and its start bit follows the last stop bit of the current frame with no idle gap.
- R6: Every bit lasts exactly 16 clock cycles in which tick_en is high. Bit timing does not advance in cycles where tick_en is low.
- R7: While rst is high, txd is driven high and buf_empty high at the next edge. Any frame in progress is abandoned, and no frame resumes after rst falls.
- R8: Parity covers only the configured data bits. In 7-bit formats din[7] is not sent and has no effect on the parity bit.
- R9: The format code is captured when a frame starts. A change to fmt during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high combined hardware/software reset |
| tick_en | input | 1 | Baud enable tick, 16 per bit |
| load | input | 1 | One-cycle strobe that captures din |
| din | input | 8 | Byte to send |
| fmt | input | 3 | Frame format code |
| txd | output | 1 | Serial line output, idle high |
| buf_empty | output | 1 | High when the holding buffer can accept a byte |

## Verification
The results of a load strobe are due at fixed cycles. buf_empty falls after the edge that sees the strobe. The start bit appears, and buf_empty rises again, after the following edge. Each later bit boundary falls 16 ticked edges after the one before it. The bench drives inputs on falling edges and counts falling edges from the load to reach each sample point. It samples every bit at its midpoint, and it samples the last and first cycle of a bit where exact timing matters: when ticks stall, at the back-to-back handoff, and after a reset.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_e;

    typedef struct packed {
        logic eight_bits;
        logic par_en;
        logic par_odd;
        logic two_stops;
    } frame_cfg_t;

endpackage

// File: rtl/tx_fmt_decode.sv
module tx_fmt_decode
    import uart_tx_pkg::*;
(
    input  logic [2:0] code,
    output frame_cfg_t cfg
);

    always_comb begin
        unique case (code)
            3'b000:  cfg = '{eight_bits: 1'b0, par_en: 1'b1, par_odd: 1'b0, two_stops: 1'b1};
            3'b001:  cfg = '{eight_bits: 1'b0, par_en: 1'b1, par_odd: 1'b1, two_stops: 1'b1};
            3'b010:  cfg = '{eight_bits: 1'b0, par_en: 1'b1, par_odd: 1'b0, two_stops: 1'b0};
            3'b011:  cfg = '{eight_bits: 1'b0, par_en: 1'b1, par_odd: 1'b1, two_stops: 1'b0};
            3'b100:  cfg = '{eight_bits: 1'b1, par_en: 1'b0, par_odd: 1'b0, two_stops: 1'b1};
            3'b101:  cfg = '{eight_bits: 1'b1, par_en: 1'b0, par_odd: 1'b0, two_stops: 1'b0};
            3'b110:  cfg = '{eight_bits: 1'b1, par_en: 1'b1, par_odd: 1'b0, two_stops: 1'b0};
            default: cfg = '{eight_bits: 1'b1, par_en: 1'b1, par_odd: 1'b1, two_stops: 1'b0};
        endcase
    end

endmodule

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              take,
    output logic [DATA_W-1:0] dout,
    output logic              empty
);

    logic full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            dout   <= '0;
        end else if (load) begin
            full_q <= 1'b1;
            dout   <= din;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    assign empty = !full_q;

    // R4: a strobe always leaves the buffer occupied
    p_load_fills_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> !empty);

    // R5: the transfer into the shifter frees the buffer
    p_take_frees_r5: assert property (@(posedge clk) disable iff (rst)
        (take && !load) |=> empty);

endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic done
);

    localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

    logic [CW-1:0] cnt;

    assign done = tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // R6: no progress through a bit without a tick
    p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(cnt));

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic [2:0]        fmt,
    output logic              txd,
    output logic              buf_empty
);

    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_LONG  = BIT_W'(DATA_W - 1);
    localparam logic [BIT_W-1:0] LAST_SHORT = BIT_W'(DATA_W - 2);

    tx_state_e         state, state_nx;
    frame_cfg_t        cfg_live, cfg_q;
    logic [DATA_W-1:0] hold_data, shreg, masked;
    logic [BIT_W-1:0]  bit_idx;
    logic              stop_idx, par_q, par_calc;
    logic              bit_done, take, last_data, last_stop;

    tx_fmt_decode u_dec (
        .code (fmt),
        .cfg  (cfg_live)
    );

    tx_hold_buf #(.DATA_W(DATA_W)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .din   (din),
        .take  (take),
        .dout  (hold_data),
        .empty (buf_empty)
    );

    tx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .clr  (state == TX_IDLE),
        .tick (tick_en),
        .done (bit_done)
    );

    // parity over the configured data width only
    always_comb begin
        masked = hold_data;
        if (!cfg_live.eight_bits) begin
            masked[DATA_W-1] = 1'b0;
        end
        par_calc = (^masked) ^ cfg_live.par_odd;
    end

    assign last_data = (bit_idx == (cfg_q.eight_bits ? LAST_LONG : LAST_SHORT));
    assign last_stop = !cfg_q.two_stops || stop_idx;
    assign take      = !buf_empty &&
                       ((state == TX_IDLE) ||
                        (state == TX_STOP && bit_done && last_stop));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:   if (!buf_empty) state_nx = TX_START;
            TX_START:  if (bit_done)   state_nx = TX_DATA;
            TX_DATA:   if (bit_done && last_data)
                           state_nx = cfg_q.par_en ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_done)   state_nx = TX_STOP;
            TX_STOP:   if (bit_done && last_stop)
                           state_nx = buf_empty ? TX_IDLE : TX_START;
            default:   state_nx = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= TX_IDLE;
        else     state <= state_nx;
    end

    // frame datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            cfg_q    <= '0;
            par_q    <= 1'b0;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
        end else if (take) begin
            shreg    <= hold_data;
            cfg_q    <= cfg_live;
            par_q    <= par_calc;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
        end else if (bit_done) begin
            if (state == TX_DATA) begin
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + 1'b1;
            end
            if (state == TX_STOP) begin
                stop_idx <= 1'b1;
            end
        end
    end

    // line output
    always_comb begin
        unique case (state)
            TX_IDLE:   txd = 1'b1;
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = shreg[0];
            TX_PARITY: txd = par_q;
            TX_STOP:   txd = 1'b1;
            default:   txd = 1'b1;
        endcase
    end

    // R6: the machine holds its state through cycles with no tick
    p_stall_r6: assert property (@(posedge clk) disable iff (rst)
        (state != TX_IDLE && !tick_en) |=> (state == $past(state)));

    // R5: a waiting byte starts a frame one edge later
    p_idle_to_start_r5: assert property (@(posedge clk) disable iff (rst)
        (state == TX_IDLE && !buf_empty) |=> (state == TX_START));

    // R7: reset leaves the line idle and the buffer free
    p_reset_idle_r7: assert property (@(posedge clk)
        rst |=> (state == TX_IDLE && buf_empty));

endmodule

// File: tb/uart_tx_framer_test.sv
`timescale 1ns/1ps
module uart_tx_framer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b1;
    logic       load = 1'b0;
    logic [7:0] din = 8'h00;
    logic [2:0] fmt = 3'b101;
    logic       txd, buf_empty;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    uart_tx_framer uut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .load      (load),
        .din       (din),
        .fmt       (fmt),
        .txd       (txd),
        .buf_empty (buf_empty)
    );

    // {fmt, din, frame length, frame bits with the start bit at bit 0}
    localparam logic [25:0] VEC [8] = '{
        {3'b000, 8'hA5, 4'd11, 11'h74A},  // R1 even, 2 stops, din[7] ignored (R8)
        {3'b001, 8'h3C, 4'd11, 11'h778},  // R1 odd, 2 stops
        {3'b010, 8'hFF, 4'd10, 11'h3FE},  // R1 even, 1 stop
        {3'b011, 8'h80, 4'd10, 11'h300},  // R1 odd, 1 stop, din[7] ignored (R8)
        {3'b100, 8'h96, 4'd11, 11'h72C},  // R2 no parity, 2 stops
        {3'b101, 8'h01, 4'd10, 11'h202},  // R2 no parity, 1 stop
        {3'b110, 8'h7E, 4'd11, 11'h4FC},  // R2 even, 1 stop
        {3'b111, 8'hC3, 4'd11, 11'h786}   // R2 odd, 1 stop
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // strobe a byte; return one falling edge after the loading edge
    task automatic strobe(input logic [2:0] f, input logic [7:0] d);
        fmt  = f;
        din  = d;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_neg(3);
        chk("R7 reset txd", txd, 1);
        chk("R7 reset buf_empty", buf_empty, 1);
        rst = 1'b0;
        wait_neg(2);

        // table walk
        for (int v = 0; v < 8; v++) begin
            logic [2:0]  f;
            logic [7:0]  d;
            logic [3:0]  n;
            logic [10:0] fr;
            {f, d, n, fr} = VEC[v];
            strobe(f, d);
            chk("R4 buf_empty after load", buf_empty, 0);
            chk("R3 idle before start", txd, 1);
            wait_neg(1);
            chk("R5 buf_empty after take", buf_empty, 1);
            wait_neg(8);
            for (int b = 0; b < int'(n); b++) begin
                chk((f[2] ? "R2 frame bit" : "R1 frame bit"), txd, fr[b]);
                if (b < int'(n) - 1) wait_neg(16);
            end
            wait_neg(8);
            chk("R3 idle after frame", txd, 1);
            chk("R5 empty after frame", buf_empty, 1);
            wait_neg(3);
        end

        // R6: stall with no ticks inside the start bit
        fmt = 3'b101;
        tick_en = 1'b0;
        strobe(3'b101, 8'h01);
        wait_neg(51);
        chk("R6 start held without ticks", txd, 0);
        tick_en = 1'b1;
        wait_neg(15);
        chk("R6 last cycle of start bit", txd, 0);
        wait_neg(1);
        chk("R6 first cycle of bit 0", txd, 1);
        wait_neg(15);
        chk("R6 last cycle of bit 0", txd, 1);
        wait_neg(1);
        chk("R6 first cycle of bit 1", txd, 0);
        wait_neg(16 * 8 + 2);
        chk("R6 idle after stalled frame", txd, 1);
        wait_neg(3);

        // R5: queue a second byte during a frame
        strobe(3'b101, 8'h01);
        wait_neg(1);
        wait_neg(20);
        strobe(3'b101, 8'h80);
        chk("R5 queued byte held", buf_empty, 0);
        wait_neg(138);
        chk("R5 last cycle of stop", txd, 1);
        chk("R5 still queued", buf_empty, 0);
        wait_neg(1);
        chk("R5 back-to-back start", txd, 0);
        chk("R5 empty at handoff", buf_empty, 1);
        wait_neg(120);
        chk("R4 queued bit 6", txd, 0);
        wait_neg(16);
        chk("R4 queued bit 7", txd, 1);
        wait_neg(24);
        chk("R5 idle after queue", txd, 1);
        wait_neg(3);

        // R9: format changed mid-frame
        strobe(3'b101, 8'h01);
        wait_neg(1);
        fmt = 3'b000;
        wait_neg(136);
        chk("R9 bit 8 keeps data format", txd, 0);
        wait_neg(16);
        chk("R9 stop at bit 9", txd, 1);
        wait_neg(8);
        chk("R9 idle at end", txd, 1);
        wait_neg(3);

        // R7: reset mid-frame
        strobe(3'b101, 8'h00);
        wait_neg(1);
        wait_neg(30);
        chk("R7 data low before reset", txd, 0);
        rst = 1'b1;
        wait_neg(1);
        rst = 1'b0;
        chk("R7 txd after reset", txd, 1);
        chk("R7 buf_empty after reset", buf_empty, 1);
        begin
            int lows = 0;
            for (int c = 0; c < 40; c++) begin
                wait_neg(1);
                if (txd !== 1'b1) lows++;
            end
            chk("R7 no resume after reset", lows, 0);
        end

        finish_run();
    end

endmodule